// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Logic

This block gathers the interrupt events of a group of DMA channels and turns them into one interrupt request line per channel. Every channel reports three kinds of event: its transfer counter reaching the end, its source address running out of its repeat window, and its destination address running out of its repeat window. Each event kind has its own enable bit. Any enabled event sets one sticky request flag for that channel. The flag does not remember which event set it. A per-channel interrupt enable then gates the flag onto the channel's request line, and each line goes to the system interrupt controller on its own.

Software reaches the enables and the flag through a small register port. The port has one register per channel. Software clears the flag by writing zero to it. The DMA engine can also clear the flag with a reload strobe when the channel's counter and address registers are rewritten.

The block also has a pending-index output. It names the highest-priority source that is both flagged and enabled, and it is zero when nothing is pending. For this output the block keeps, per channel, the source that most recently set the flag.

Top module: `dma_irq_flags`

## Requirements
- R1: After a synchronous active-high reset, all source enables, channel enables and flags are 0, every `irq_o` bit is 0, `pend_o` is 0, and reads return 0.
- R2: Register `c` (address = channel index) has this layout: bit 0 is the transfer-end enable, bit 1 is the source-repeat enable, bit 2 is the destination-repeat enable, bit 3 is the channel interrupt enable and bit 4 is the flag. `rd_data_o` is registered: it shows the state addressed by `rd_addr_i` as it stood before the clock edge that samples that address.
- R3: An event pulse on `evt_i[c*3+s]` whose source enable is 1 sets the flag of channel `c` at that clock edge.
- R4: An event whose source enable is 0 is ignored. It does not set the flag, and it does not set it later when the enable is turned on afterwards.
- R5: `irq_o[c]` is 1 exactly when channel `c` has its flag and its channel interrupt enable both at 1. It changes in the same cycle as those bits.
- R6: Writing 0 to the flag bit clears the flag. Writing 1 to the flag bit leaves the flag unchanged.
- R7: A pulse on `reload_i[c]` clears the flag of channel `c`.
- R8: When an enabled event and a clear (by write or by reload) reach the same channel on the same edge, the flag ends up set.
- R9: Clearing the channel interrupt enable drops `irq_o[c]` without changing the flag. Setting the enable again raises `irq_o[c]` if the flag is still 1.
- R10: The channels are independent. Events, writes and reloads aimed at one channel leave the flag, enables and request line of every other channel unchanged.
- R11: `pend_o` is 0 when no channel has both its flag and its enable set. Otherwise it is `1 + 3*c + s`. Here `c` is the lowest-numbered such channel, because lower channels rank higher. `s` is the source that most recently set that channel's flag, where transfer end = 0, source repeat = 1 and destination repeat = 2. When several enabled sources fire together, the lowest `s` is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH*NSRC | Event pulses, bit c*NSRC+s = channel c, source s |
| reload_i | input | NCH | Per-channel reload strobe that clears the flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address (channel index) |
| wr_data_i | input | NSRC+2 | Register write data |
| rd_addr_i | input | AW | Register read address (channel index) |
| rd_data_o | output | NSRC+2 | Registered read data |
| irq_o | output | NCH | Per-channel interrupt request |
| pend_o | output | PW | Highest-priority pending source index, 0 if none |

## Verification
The bench builds the block with its defaults: two channels of three sources each. With these values every pending code from 0 to 6 can be produced, and the priority contest between the two channels is exercised. Random cycles place events, clears, reloads and enable writes on the same edge, which covers the set-beats-clear case and the case of a write to one channel while the other channel has events. The write and read address is one bit wide, so an out-of-range address cannot be driven with these values.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum int {
    SRC_XFER_END = 0,
    SRC_SRC_WRAP = 1,
    SRC_DST_WRAP = 2
  } src_kind_e;

  localparam int SRC_COUNT = 3;

  // bit positions inside a channel register, relative to the source count
  function automatic int ie_bit(input int nsrc);
    return nsrc;
  endfunction

  function automatic int flag_bit(input int nsrc);
    return nsrc + 1;
  endfunction
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
#(
  parameter int NSRC = SRC_COUNT,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DW  = NSRC + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] evt,
  input  logic            reload,
  output logic [NSRC-1:0] en_q,
  output logic            ie_q,
  output logic            flag_q,
  output logic [SW-1:0]   last_q,
  output logic            flag_d,
  output logic            ie_d,
  output logic [SW-1:0]   last_d
);
  localparam int IEB = ie_bit(NSRC);
  localparam int FLB = flag_bit(NSRC);

  logic [NSRC-1:0] hit;
  logic            clr;
  logic [NSRC-1:0] en_d;

  assign hit = evt & en_q;

  always_comb begin
    clr    = reload | (wr_sel & ~wr_data[FLB]);
    en_d   = wr_sel ? wr_data[NSRC-1:0] : en_q;
    ie_d   = wr_sel ? wr_data[IEB] : ie_q;
    if (|hit)
      flag_d = 1'b1;
    else if (clr)
      flag_d = 1'b0;
    else
      flag_d = flag_q;
    last_d = last_q;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (hit[s]) last_d = SW'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      last_q <= '0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      last_q <= last_d;
    end
  end

  // R3
  enabled_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|(evt & en_q)) |=> flag_q);

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(|(evt & en_q))) |=> !flag_q);

  // R7
  reload_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reload && !(|(evt & en_q))) |=> !flag_q);

  // R6
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wr_data[FLB] && !reload && !(|(evt & en_q))) |=> $stable(flag_q));

  // R9
  ie_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (ie_q == $past(wr_data[IEB])));
endmodule

// File: rtl/dma_irq_prio.sv
module dma_irq_prio #(
  parameter int NCH  = 2,
  parameter int NSRC = 3,
  parameter int SW   = 2,
  parameter int PW   = 3
) (
  input  logic [NCH-1:0] act,
  input  logic [SW-1:0]  last [NCH],
  output logic [PW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (act[c]) idx = PW'(c * NSRC + int'(last[c]) + 1);
    end
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NSRC = SRC_COUNT,
  localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW  = NSRC + 2,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int PW  = $clog2(NCH * NSRC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH*NSRC-1:0]  evt_i,
  input  logic [NCH-1:0]       reload_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DW-1:0]        rd_data_o,
  output logic [NCH-1:0]       irq_o,
  output logic [PW-1:0]        pend_o
);
  logic [NSRC-1:0] en_q   [NCH];
  logic [SW-1:0]   last_q [NCH];
  logic [SW-1:0]   last_d [NCH];
  logic [NCH-1:0]  ie_q, ie_d, flag_q, flag_d;
  logic [PW-1:0]   pend_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_sel;
    assign wr_sel = wr_en_i && (int'(wr_addr_i) == c);

    dma_irq_chan #(.NSRC(NSRC), .SW(SW)) i_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_data (wr_data_i),
      .evt     (evt_i[c*NSRC +: NSRC]),
      .reload  (reload_i[c]),
      .en_q    (en_q[c]),
      .ie_q    (ie_q[c]),
      .flag_q  (flag_q[c]),
      .last_q  (last_q[c]),
      .flag_d  (flag_d[c]),
      .ie_d    (ie_d[c]),
      .last_d  (last_d[c])
    );
  end

  dma_irq_prio #(.NCH(NCH), .NSRC(NSRC), .SW(SW), .PW(PW)) i_prio (
    .act  (flag_d & ie_d),
    .last (last_d),
    .idx  (pend_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= '0;
      pend_o    <= '0;
      rd_data_o <= '0;
    end else begin
      irq_o  <= flag_d & ie_d;
      pend_o <= pend_d;
      if (int'(rd_addr_i) < NCH)
        rd_data_o <= {flag_q[rd_addr_i], ie_q[rd_addr_i], en_q[rd_addr_i]};
      else
        rd_data_o <= '0;
    end
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_q & ie_q));

  // R11
  pend_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_o == '0) == (irq_o == '0));

  // R11
  pend_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pend_o) <= NCH * NSRC);
endmodule

// File: tb/test_dma_irq_flags.sv
`timescale 1ns/1ps
module test_dma_irq_flags;
  localparam int NCH = 2;
  localparam int NSRC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] evt_i = '0;
  logic [1:0] reload_i = '0;
  logic wr_en_i = 1'b0;
  logic [0:0] wr_addr_i = '0;
  logic [4:0] wr_data_i = '0;
  logic [0:0] rd_addr_i = '0;
  logic [4:0] rd_data_o;
  logic [1:0] irq_o;
  logic [2:0] pend_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  bit [2:0] m_en [NCH];
  bit m_ie [NCH];
  bit m_fl [NCH];
  int m_last [NCH];

  always #5 clk = ~clk;

  dma_irq_flags i_dma_irq_flags (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reload_i(reload_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .pend_o(pend_o)
  );

  function automatic logic [4:0] exp_reg(input int c);
    return {m_fl[c], m_ie[c], m_en[c]};
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = m_fl[c] & m_ie[c];
    return r;
  endfunction

  function automatic logic [2:0] exp_pend();
    for (int c = 0; c < NCH; c++)
      if (m_fl[c] && m_ie[c]) return 3'(c * NSRC + m_last[c] + 1);
    return 3'd0;
  endfunction

  task automatic model_step(input logic [5:0] ev, input logic [1:0] rl,
                            input bit we, input int wa, input logic [4:0] wd);
    for (int c = 0; c < NCH; c++) begin
      bit [2:0] hit;
      bit clr;
      hit = ev[c*NSRC +: NSRC] & m_en[c];
      clr = rl[c] || (we && wa == c && !wd[4]);
      if (hit != 0) begin
        m_fl[c] = 1;
        for (int s = NSRC - 1; s >= 0; s--) if (hit[s]) m_last[c] = s;
      end else if (clr) begin
        m_fl[c] = 0;
      end
      if (we && wa == c) begin
        m_en[c] = wd[2:0];
        m_ie[c] = wd[3];
      end
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] ev, input logic [1:0] rl, input bit we,
                     input int wa, input logic [4:0] wd, input int ra, input string tag);
    logic [4:0] erd;
    evt_i = ev; reload_i = rl; wr_en_i = we; wr_addr_i = 1'(wa);
    wr_data_i = wd; rd_addr_i = 1'(ra);
    erd = exp_reg(ra);
    @(posedge clk);
    model_step(ev, rl, we, wa, wd);
    @(negedge clk);
    check(tag, "rd_data", int'(rd_data_o), int'(erd));
    check(tag, "irq", int'(irq_o), int'(exp_irq()));
    check(tag, "pend", int'(pend_o), int'(exp_pend()));
  endtask

  task automatic idle(input int ra, input string tag);
    cyc(6'd0, 2'd0, 0, 0, 5'd0, ra, tag);
  endtask

  initial begin
    int seed_v;
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_ie[c] = 0; m_fl[c] = 0; m_last[c] = 0;
    end
    seed_v = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    idle(0, "R1");
    idle(1, "R1");
    // R2 layout: ch0 transfer-end enable + channel enable
    cyc(6'd0, 2'd0, 1, 0, 5'b01001, 0, "R2");
    idle(0, "R2");
    // R3 R5 enabled event sets flag and request
    cyc(6'b000001, 2'd0, 0, 0, 5'd0, 0, "R3");
    idle(0, "R5");
    // R4 disabled event on ch1 ignored, late enable does not set
    cyc(6'd0, 2'd0, 1, 1, 5'b01000, 1, "R4");
    cyc(6'b010000, 2'd0, 0, 0, 5'd0, 1, "R4");
    cyc(6'd0, 2'd0, 1, 1, 5'b01010, 1, "R4");
    idle(1, "R4");
    // R9 R6 mask with flag bit written 1: flag kept, request drops
    cyc(6'd0, 2'd0, 1, 0, 5'b10001, 0, "R9");
    idle(0, "R6");
    cyc(6'd0, 2'd0, 1, 0, 5'b11001, 0, "R9");
    idle(0, "R9");
    // R8 clear by write and event same edge
    cyc(6'b000001, 2'd0, 1, 0, 5'b01001, 0, "R8");
    idle(0, "R8");
    // R7 reload clears
    cyc(6'd0, 2'b01, 0, 0, 5'd0, 0, "R7");
    idle(0, "R7");
    // R8 reload and event same edge
    cyc(6'b000001, 2'b01, 0, 0, 5'd0, 0, "R8");
    // R6 write 0 clears
    cyc(6'd0, 2'd0, 1, 0, 5'b01001, 0, "R6");
    idle(0, "R6");
    // R11 R10 priority across channels
    cyc(6'd0, 2'd0, 1, 1, 5'b01111, 1, "R10");
    cyc(6'b100000, 2'd0, 0, 0, 5'd0, 1, "R11");
    cyc(6'd0, 2'd0, 1, 0, 5'b01010, 0, "R10");
    cyc(6'b000010, 2'd0, 0, 0, 5'd0, 0, "R11");
    cyc(6'b011000, 2'b01, 0, 0, 5'd0, 1, "R11");
    idle(1, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ev;
      logic [1:0] rl;
      bit we;
      ev = '0;
      for (int b = 0; b < 6; b++) ev[b] = (($urandom % 4) == 0);
      rl[0] = (($urandom % 12) == 0);
      rl[1] = (($urandom % 12) == 0);
      we = (($urandom % 6) == 0);
      cyc(ev, rl, we, int'($urandom % 2), 5'($urandom), int'($urandom % 2), "R11");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule